// File: doc/BRIEF.md
# One-Hot Token Deserializer

This block gathers a serial stream of single bits into bytes. Rather than shifting every stored bit on each arrival, it keeps a circulating one-hot token. The token points at exactly one storage cell, and only that cell captures the bit on the input. The other cells keep their values, so no bit ripples through a chain.

When the cell at token position 0 is written, the byte is complete. All cells, together with the bit arriving in that cycle, are copied into an output register. A valid/ready handshake then offers the byte to a consumer. A new copy can only follow a full byte of accepted bits later, so the output register stays put for at least seven further bit arrivals. That gives a slow consumer time to take the byte.

A restart input sends the token back to its first position, so the next accepted bit opens a new byte. If a byte completes while the previous one is still unclaimed, the new byte replaces the old one and a sticky overrun flag is raised.

Top module: `tokdes_top`

## Requirements
- R1: While reset is asserted and directly after it, `byte_valid_o` and `overrun_o` are 0 and `byte_data_o` is all zeros. From the first rising clock edge after reset is released, `bit_ready_o` is 1 whenever `start_i` is 0.
- R2: With default parameters the byte is assembled MSB first: the first bit accepted after reset or restart lands in bit 7 of `byte_data_o`, and the eighth lands in bit 0.
- R3: `byte_valid_o` becomes 1 after the clock edge that accepts the eighth bit of a byte, and `byte_data_o` then holds all eight bits.
- R4: A bit is accepted only on an edge where both `bit_valid_i` and `bit_ready_o` are 1. Cycles without acceptance do not move the token and do not change the byte that is eventually delivered.
- R5: While `start_i` is 1, `bit_ready_o` is 0 and any offered bit is dropped. After that edge the token is at its first position, so bits gathered before the restart are discarded and the next eight accepted bits form the next byte.
- R6: Once `byte_valid_o` is 1, it and `byte_data_o` stay unchanged until an edge where `byte_ready_i` is 1. After that edge `byte_valid_o` is 0, unless a new byte completes on the same edge.
- R7: `byte_data_o` does not change during the seven bit acceptances that follow a byte copy. It changes only on the edge that accepts the eighth following bit.
- R8: If a byte completes while `byte_valid_o` is 1 and `byte_ready_i` is 0, `overrun_o` becomes 1 and the new byte replaces the old one with `byte_valid_o` still 1. `overrun_o` stays 1 until `start_i` is asserted or reset occurs.
- R9: If a byte completes on the same edge that the consumer takes the previous byte, `overrun_o` does not change and the new byte is presented with `byte_valid_o` at 1.
- R10: With bits offered every cycle and `byte_ready_i` held at 1, every byte is delivered one cycle after its last bit, with no bit lost between bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Restart: token back to first position, clears overrun |
| bit_valid_i | input | 1 | Serial bit is offered |
| bit_data_i | input | 1 | Serial bit value |
| bit_ready_o | output | 1 | Block can accept a bit |
| byte_valid_o | output | 1 | Assembled byte is available |
| byte_data_o | output | W | Assembled byte |
| byte_ready_i | input | 1 | Consumer takes the byte |
| overrun_o | output | 1 | Sticky: an unclaimed byte was replaced |

## Verification
The hardest case to reach from the ports is a byte completing on exactly the edge where the consumer takes the previous byte. The overrun rule and the consume rule must both resolve on that one edge. The stimulus leaves a byte unclaimed, streams a second byte, and raises `byte_ready_i` only while the eighth bit is offered. It then confirms that the flag stays clear and the new byte is valid. The hold window is covered by sampling `byte_data_o` after each of the seven bits that follow an unclaimed byte, before the overrun replacement.

// File: rtl/tokdes_pkg.sv
package tokdes_pkg;
   parameter int TOKDES_DEF_W = 8;

   // position that receives the first bit of a word
   function automatic int first_pos(input int w);
      return w - 1;
   endfunction
endpackage

// File: rtl/tokdes_ring.sv
module tokdes_ring #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart,
   input  logic         adv,
   output logic [W-1:0] tok,
   output logic         at_last
);
   localparam logic [W-1:0] TOK_HOME = {1'b1, {(W-1){1'b0}}};

   logic [W-1:0] tok_q, tok_d;

   always_comb begin
      tok_d = tok_q;
      if (restart)
         tok_d = TOK_HOME;
      else if (adv)
         tok_d = {tok_q[0], tok_q[W-1:1]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tok_q <= TOK_HOME;
      else
         tok_q <= tok_d;
   end

   assign tok     = tok_q;
   assign at_last = tok_q[0];
endmodule

// File: rtl/tokdes_cells.sv
module tokdes_cells #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] tok,
   input  logic         din,
   output logic [W-1:0] cell_nxt
);
   logic [W-1:0] cell_q;

   for (genvar gi = 0; gi < W; gi++) begin : g_cell
      logic sel;
      assign sel = wr_en & tok[gi];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cell_q[gi] <= 1'b0;
         else if (sel)
            cell_q[gi] <= din;
      end

      // forward the bit being written so the completing bit joins the copy
      assign cell_nxt[gi] = sel ? din : cell_q[gi];
   end
endmodule

// File: rtl/tokdes_outreg.sv
module tokdes_outreg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] din,
   input  logic         consume,
   input  logic         clr_ovr,
   output logic         valid,
   output logic [W-1:0] data,
   output logic         ovr
);
   logic         valid_q, ovr_q;
   logic [W-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         data_q  <= '0;
         ovr_q   <= 1'b0;
      end else begin
         if (load) begin
            data_q  <= din;
            valid_q <= 1'b1;
            if (valid_q && !consume)
               ovr_q <= 1'b1;
         end else if (consume) begin
            valid_q <= 1'b0;
         end
         if (clr_ovr)
            ovr_q <= 1'b0;
      end
   end

   assign valid = valid_q;
   assign data  = data_q;
   assign ovr   = ovr_q;
endmodule

// File: rtl/tokdes_top.sv
module tokdes_top
   import tokdes_pkg::*;
#(
   parameter int W         = TOKDES_DEF_W,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic         bit_valid_i,
   input  logic         bit_data_i,
   output logic         bit_ready_o,
   output logic         byte_valid_o,
   output logic [W-1:0] byte_data_o,
   input  logic         byte_ready_i,
   output logic         overrun_o
);
   localparam int HOME = first_pos(W);

   if (W < 2) begin : g_bad_w
      $error("tokdes_top: W must be at least 2");
   end
   if (HOME != W - 1) begin : g_bad_home
      $error("tokdes_top: first token position must be the top cell");
   end

   logic         rdy_q;
   logic         bit_acc;
   logic         byte_load;
   logic         tok_last;
   logic [W-1:0] tok_q;
   logic [W-1:0] cell_nxt;
   logic [W-1:0] word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdy_q <= 1'b0;
      else
         rdy_q <= 1'b1;
   end

   assign bit_ready_o = rdy_q & ~start_i;
   assign bit_acc     = bit_valid_i & bit_ready_o;
   assign byte_load   = bit_acc & tok_last;

   tokdes_ring #(.W(W)) u_ring (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (start_i),
      .adv     (bit_acc),
      .tok     (tok_q),
      .at_last (tok_last)
   );

   tokdes_cells #(.W(W)) u_cells (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bit_acc),
      .tok      (tok_q),
      .din      (bit_data_i),
      .cell_nxt (cell_nxt)
   );

   if (MSB_FIRST) begin : g_msb
      assign word = cell_nxt;
   end else begin : g_lsb
      for (genvar gj = 0; gj < W; gj++) begin : g_map
         assign word[gj] = cell_nxt[W-1-gj];
      end
   end

   tokdes_outreg #(.W(W)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (byte_load),
      .din     (word),
      .consume (byte_ready_i),
      .clr_ovr (start_i),
      .valid   (byte_valid_o),
      .data    (byte_data_o),
      .ovr     (overrun_o)
   );
endmodule

// File: rtl/tokdes_chk.sv
module tokdes_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start_i,
   input logic         bit_ready_o,
   input logic         byte_valid_o,
   input logic [W-1:0] byte_data_o,
   input logic         byte_ready_i,
   input logic         overrun_o,
   input logic [W-1:0] tok,
   input logic         load,
   input logic         accept
);
   localparam logic [W-1:0] HOME = {1'b1, {(W-1){1'b0}}};

   int gap;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         gap <= W - 1;
      else if (load)
         gap <= 0;
      else if (accept && gap < W)
         gap <= gap + 1;
   end

   assert_tok_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(tok) == 1);

   assert_tok_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!accept && !start_i) |=> $stable(tok));

   assert_start_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> !bit_ready_o);

   assert_start_home_R5: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> tok == HOME);

   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid_o && !byte_ready_i && !load) |=> (byte_valid_o && $stable(byte_data_o)));

   assert_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid_o && byte_ready_i && !load) |=> !byte_valid_o);

   assert_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> gap >= W - 1);

   assert_ovr_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (load && byte_valid_o && !byte_ready_i) |=> overrun_o);

   assert_ovr_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (load && byte_ready_i && !start_i) |=> (byte_valid_o && $stable(overrun_o)));
endmodule

bind tokdes_top tokdes_chk #(.W(W)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .start_i      (start_i),
   .bit_ready_o  (bit_ready_o),
   .byte_valid_o (byte_valid_o),
   .byte_data_o  (byte_data_o),
   .byte_ready_i (byte_ready_i),
   .overrun_o    (overrun_o),
   .tok          (tok_q),
   .load         (byte_load),
   .accept       (bit_acc)
);

// File: tb/tokdes_top_tb_top.sv
module tokdes_top_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       bit_valid_i = 1'b0;
   logic       bit_data_i = 1'b0;
   logic       bit_ready_o;
   logic       byte_valid_o;
   logic [7:0] byte_data_o;
   logic       byte_ready_i = 1'b0;
   logic       overrun_o;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   tokdes_top dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .bit_valid_i  (bit_valid_i),
      .bit_data_i   (bit_data_i),
      .bit_ready_o  (bit_ready_o),
      .byte_valid_o (byte_valid_o),
      .byte_data_o  (byte_data_o),
      .byte_ready_i (byte_ready_i),
      .overrun_o    (overrun_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // offer one bit per cycle; entered and left at a falling edge
   task automatic send_byte(input logic [7:0] b, input logic last_rdy);
      for (int i = 0; i < 8; i++) begin
         bit_valid_i = 1'b1;
         bit_data_i  = b[7-i];
         if (i == 7) byte_ready_i = last_rdy;
         @(negedge clk);
      end
      bit_valid_i  = 1'b0;
      byte_ready_i = 1'b0;
   endtask

   task automatic consume();
      byte_ready_i = 1'b1;
      @(negedge clk);
      byte_ready_i = 1'b0;
   endtask

   task automatic t_reset();
      check(byte_valid_o == 1'b0, "R1 valid in reset", byte_valid_o, 0);
      check(overrun_o == 1'b0, "R1 overrun in reset", overrun_o, 0);
      check(byte_data_o == 8'h00, "R1 data in reset", byte_data_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(bit_ready_o == 1'b1, "R1 ready after reset", bit_ready_o, 1);
      check(byte_valid_o == 1'b0, "R1 valid after reset", byte_valid_o, 0);
   endtask

   task automatic t_basic();
      send_byte(8'h80, 1'b0);
      check(byte_valid_o == 1'b1, "R3 valid after eighth bit", byte_valid_o, 1);
      check(byte_data_o == 8'h80, "R2 first bit is MSB", byte_data_o, 8'h80);
      consume();
      send_byte(8'hA5, 1'b0);
      check(byte_data_o == 8'hA5, "R3 byte content", byte_data_o, 8'hA5);
      for (int k = 0; k < 3; k++) @(negedge clk);
      check(byte_valid_o == 1'b1, "R6 valid held", byte_valid_o, 1);
      check(byte_data_o == 8'hA5, "R6 data held", byte_data_o, 8'hA5);
      consume();
      check(byte_valid_o == 1'b0, "R6 valid drops after take", byte_valid_o, 0);
   endtask

   task automatic t_gaps();
      logic [7:0] b = 8'h3C;
      for (int i = 0; i < 8; i++) begin
         bit_valid_i = 1'b1;
         bit_data_i  = b[7-i];
         @(negedge clk);
         bit_valid_i = 1'b0;
         bit_data_i  = ~b[7-i];
         @(negedge clk);
         @(negedge clk);
      end
      check(byte_valid_o == 1'b1, "R4 valid after sparse bits", byte_valid_o, 1);
      check(byte_data_o == 8'h3C, "R4 idle cycles ignored", byte_data_o, 8'h3C);
      consume();
   endtask

   task automatic t_start();
      for (int i = 0; i < 3; i++) begin
         bit_valid_i = 1'b1;
         bit_data_i  = 1'b1;
         @(negedge clk);
      end
      start_i    = 1'b1;
      bit_data_i = 1'b1;
      #1;
      check(bit_ready_o == 1'b0, "R5 ready low during start", bit_ready_o, 0);
      @(negedge clk);
      start_i     = 1'b0;
      bit_valid_i = 1'b0;
      send_byte(8'h96, 1'b0);
      check(byte_valid_o == 1'b1, "R5 valid after restart", byte_valid_o, 1);
      check(byte_data_o == 8'h96, "R5 partial bits discarded", byte_data_o, 8'h96);
      consume();
   endtask

   task automatic t_overrun();
      logic [7:0] b = 8'h22;
      send_byte(8'h11, 1'b0);
      for (int i = 0; i < 7; i++) begin
         bit_valid_i = 1'b1;
         bit_data_i  = b[7-i];
         @(negedge clk);
         check(byte_data_o == 8'h11, "R7 byte stable during next bits", byte_data_o, 8'h11);
      end
      bit_data_i = b[0];
      @(negedge clk);
      bit_valid_i = 1'b0;
      check(overrun_o == 1'b1, "R8 overrun set", overrun_o, 1);
      check(byte_data_o == 8'h22, "R8 new byte replaces", byte_data_o, 8'h22);
      check(byte_valid_o == 1'b1, "R8 valid stays", byte_valid_o, 1);
      consume();
      check(overrun_o == 1'b1, "R8 overrun sticky", overrun_o, 1);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check(overrun_o == 1'b0, "R8 start clears overrun", overrun_o, 0);
   endtask

   task automatic t_same_edge();
      send_byte(8'h5A, 1'b0);
      send_byte(8'hC3, 1'b1);
      check(overrun_o == 1'b0, "R9 no overrun on same-edge take", overrun_o, 0);
      check(byte_valid_o == 1'b1, "R9 new byte valid", byte_valid_o, 1);
      check(byte_data_o == 8'hC3, "R9 new byte data", byte_data_o, 8'hC3);
      consume();
   endtask

   task automatic t_stream();
      logic [7:0] pat [4] = '{8'hF0, 8'h0F, 8'hFF, 8'h69};
      byte_ready_i = 1'b1;
      for (int k = 0; k < 4; k++) begin
         for (int i = 0; i < 8; i++) begin
            bit_valid_i = 1'b1;
            bit_data_i  = pat[k][7-i];
            @(negedge clk);
         end
         check(byte_valid_o == 1'b1, "R10 stream valid", byte_valid_o, 1);
         check(byte_data_o == pat[k], "R10 stream byte", byte_data_o, pat[k]);
      end
      bit_valid_i = 1'b0;
      @(negedge clk);
      byte_ready_i = 1'b0;
      check(byte_valid_o == 1'b0, "R10 stream drained", byte_valid_o, 0);
      check(overrun_o == 1'b0, "R10 no overrun in stream", overrun_o, 0);
   endtask

   initial begin
      #5;
      @(negedge clk);
      t_reset();
      t_basic();
      t_gaps();
      t_start();
      t_overrun();
      t_same_edge();
      t_stream();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule